// File: doc/BRIEF.md
# Radio Operating-Mode Sequencer

This block is the operating-mode controller of a low-power radio modem. It holds the modem in one of nine states. Off is held while the reset pin is low. Waking is a timed transition into Idle. Idle is the resting state. Hibernate and Doze are two sleep states. Warmup is a timed lead-in to the radio. Receive and Transmit are the two active radio states. Hold is entered after a finished sequence and waits for the enable pin to be released. All time is counted in core clock ticks. Parameters set the boot, wake and warm-up durations. At a 16 MHz core clock the warm-up default is 2304 ticks (144 µs).

The transitions are named as follows:
- **boot**: Off to Waking, on reset release.
- **settle**: Waking to Idle, when the wake count expires.
- **sleep**: Idle to Hibernate or Doze, on a low-power request.
- **attention wake**: Hibernate or Doze to Waking, on the active-low attention pin.
- **timer wake**: Doze to Waking, on a timer-comparator match.
- **start**: Idle to Warmup, on a rising edge of the RX/TX enable pin.
- **arm**: Warmup to Receive or Transmit, when the warm-up count expires.
- **finish**: Receive or Transmit to Hold, when the datapath reports the sequence complete.
- **release**: Warmup, Receive, Transmit or Hold to Idle, whenever the RX/TX enable pin is low.

The block also drives an antenna-bias control pin, given as a value plus an output enable. The pin follows the port mode, an invert bit and the radio state. An optional out-of-idle status is provided for an alternate general-purpose pin function.

Top module: `radio_mode_ctrl`

## Requirements
- R1: While `rst_n` is low the block is in Off. `mode_o` uses these codes: Off=0, Hibernate=1, Doze=2, Waking=3, Idle=4, Warmup=5, Receive=6, Transmit=7, Hold=8.
- R2: On the first clock with `rst_n` high, Off moves to Waking. Waking lasts exactly BOOT_TICKS cycles, then the block enters Idle.
- R3: In Idle, a high `lp_req` enters Hibernate when `lp_hib_sel`=1 and Doze when it is 0. In any other state `lp_req` is ignored. A start edge in the same cycle takes priority over `lp_req`.
- R4: Hibernate is left only when `attn_n` is low, and `tmr_match` has no effect there. It then passes through Waking for exactly HIB_WAKE_TICKS cycles.
- R5: Doze is left when `attn_n` is low or `tmr_match` is high. It then passes through Waking for exactly DOZE_WAKE_TICKS cycles.
- R6: In Idle, a rising edge of `rxtx_en` enters Warmup, and `seq_tx_sel` is captured at that edge. Warmup lasts WARM_TICKS cycles and then enters Transmit if the captured value was 1, or Receive if it was 0. `rxtx_en` that is held high with no edge starts nothing. `rx_on_o` is high exactly in Receive, and `tx_on_o` is high exactly in Transmit.
- R7: When `rxtx_en` is low in Warmup, Receive, Transmit or Hold, the block is in Idle on the next cycle.
- R8: When `seq_cmpl` is high in Receive or Transmit while `rxtx_en` is high, the block enters Hold. `seq_done_o` is high for exactly the first cycle in Hold. Hold lasts until `rxtx_en` goes low.
- R9: `bias_oe_o` is 1 only when `bias_en`=1 and the state is not Off. Whenever `bias_oe_o` is 0, `bias_o` is 0.
- R10: When the bias pin is enabled and `bias_dual`=0, `bias_o` is 1 in Transmit and 0 in Receive, whatever the value of `bias_inv`.
- R11: When the bias pin is enabled and `bias_dual`=1, `bias_o` equals (state is Transmit) XOR `bias_inv` in Receive and Transmit.
- R12: When the bias pin is enabled, `bias_o` is 0 in every state other than Receive and Transmit.
- R13: `out_of_idle_o` is high when `alt_gpio_en`=1 and the state is Warmup, Receive, Transmit or Hold. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Reset pin, active low; holds the block in Off |
| attn_n | input | 1 | Attention pin, active low; wakes Hibernate or Doze |
| rxtx_en | input | 1 | RX/TX enable; a rising edge starts a sequence, a low level forces Idle |
| seq_tx_sel | input | 1 | Sequence direction setting: 1 selects Transmit, 0 selects Receive |
| lp_req | input | 1 | Low-power entry request from the register file |
| lp_hib_sel | input | 1 | Low-power target: 1 selects Hibernate, 0 selects Doze |
| tmr_match | input | 1 | Timer-comparator match used as a Doze wake source |
| seq_cmpl | input | 1 | Datapath reports the RX or TX sequence finished |
| bias_en | input | 1 | Bias pin output enable setting |
| bias_dual | input | 1 | Port mode: 1 = dual port, 0 = single port |
| bias_inv | input | 1 | Bias sense invert (used only in dual-port mode) |
| alt_gpio_en | input | 1 | Enables the out-of-idle alternate pin function |
| mode_o | output | 4 | Current state code |
| rx_on_o | output | 1 | Receive state active |
| tx_on_o | output | 1 | Transmit state active |
| seq_done_o | output | 1 | One-cycle pulse on entry to Hold |
| out_of_idle_o | output | 1 | Out-of-idle status for the alternate pin |
| bias_o | output | 1 | Antenna-bias pin value |
| bias_oe_o | output | 1 | Antenna-bias pin drive enable (0 = high impedance) |

## Verification
Directed cases come first. One holds `rxtx_en` high across reset release, which separates an edge-triggered start from a level-triggered one. Another counts Warmup and Waking cycles, which exposes off-by-one timers in each wake path. Timer matches are driven into Hibernate and then into Doze, to show that only Doze treats the timer as a wake source. A single-port run with the invert bit set is followed by a dual-port run with it set, which tells the two bias rules apart. After that, weighted random toggling of every input is compared each cycle against a bench state model. That stage catches wrong priorities between a start edge and a low-power request, direction capture at the start edge rather than later, and aborts from every active state.

// File: rtl/mode_pkg.sv
package mode_pkg;

    typedef enum logic [3:0] {
        MS_OFF  = 4'd0,
        MS_HIB  = 4'd1,
        MS_DOZE = 4'd2,
        MS_WAKE = 4'd3,
        MS_IDLE = 4'd4,
        MS_WARM = 4'd5,
        MS_RX   = 4'd6,
        MS_TX   = 4'd7,
        MS_HOLD = 4'd8
    } mode_e;

    // A sequence owns the radio from the start edge until release
    function automatic logic seq_busy(input mode_e m);
        return (m == MS_WARM) || (m == MS_RX) || (m == MS_TX) || (m == MS_HOLD);
    endfunction

endpackage

// File: rtl/mode_timer.sv
module mode_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import mode_pkg::*;
#(
    parameter int BOOT_TICKS      = 160000,
    parameter int HIB_WAKE_TICKS  = 112000,
    parameter int DOZE_WAKE_TICKS = 4800,
    parameter int WARM_TICKS      = 2304
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  attn_n,
    input  logic  rxtx_en,
    input  logic  seq_tx_sel,
    input  logic  lp_req,
    input  logic  lp_hib_sel,
    input  logic  tmr_match,
    input  logic  seq_cmpl,
    output mode_e state,
    output logic  rx_on,
    output logic  tx_on,
    output logic  seq_done,
    output logic  busy
);

    localparam int MAX_A = (BOOT_TICKS > HIB_WAKE_TICKS) ? BOOT_TICKS : HIB_WAKE_TICKS;
    localparam int MAX_B = (DOZE_WAKE_TICKS > WARM_TICKS) ? DOZE_WAKE_TICKS : WARM_TICKS;
    localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = (MAXT < 2) ? 1 : $clog2(MAXT);

    localparam logic [TW-1:0] LD_BOOT = TW'(BOOT_TICKS - 1);
    localparam logic [TW-1:0] LD_HIB  = TW'(HIB_WAKE_TICKS - 1);
    localparam logic [TW-1:0] LD_DOZE = TW'(DOZE_WAKE_TICKS - 1);
    localparam logic [TW-1:0] LD_WARM = TW'(WARM_TICKS - 1);

    mode_e         nxt;
    logic          rxtx_q;
    logic          dir_tx_q;
    logic          done_q;
    logic          start_edge;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_run;
    logic          tmr_exp;

    assign start_edge = rxtx_en && !rxtx_q;
    assign tmr_run    = (state == MS_WAKE) || (state == MS_WARM);

    mode_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expired  (tmr_exp)
    );

    // Transition logic
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            MS_OFF: begin
                nxt      = MS_WAKE;
                tmr_load = 1'b1;
                tmr_val  = LD_BOOT;
            end
            MS_WAKE: begin
                if (tmr_exp) nxt = MS_IDLE;
            end
            MS_IDLE: begin
                if (start_edge) begin
                    nxt      = MS_WARM;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WARM;
                end else if (lp_req) begin
                    nxt = lp_hib_sel ? MS_HIB : MS_DOZE;
                end
            end
            MS_HIB: begin
                if (!attn_n) begin
                    nxt      = MS_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HIB;
                end
            end
            MS_DOZE: begin
                if (!attn_n || tmr_match) begin
                    nxt      = MS_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_DOZE;
                end
            end
            MS_WARM: begin
                if (!rxtx_en)     nxt = MS_IDLE;
                else if (tmr_exp) nxt = dir_tx_q ? MS_TX : MS_RX;
            end
            MS_RX, MS_TX: begin
                if (!rxtx_en)      nxt = MS_IDLE;
                else if (seq_cmpl) nxt = MS_HOLD;
            end
            MS_HOLD: begin
                if (!rxtx_en) nxt = MS_IDLE;
            end
            default: nxt = MS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= MS_OFF;
            rxtx_q   <= 1'b0;
            dir_tx_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state  <= nxt;
            rxtx_q <= rxtx_en;
            done_q <= (nxt == MS_HOLD) && (state != MS_HOLD);
            if ((state == MS_IDLE) && start_edge) dir_tx_q <= seq_tx_sel;
        end
    end

    // Outputs
    always_comb begin
        rx_on    = (state == MS_RX);
        tx_on    = (state == MS_TX);
        busy     = seq_busy(state);
        seq_done = done_q;
    end

endmodule

// File: rtl/bias_drive.sv
module bias_drive
    import mode_pkg::*;
(
    input  mode_e state,
    input  logic  bias_en,
    input  logic  bias_dual,
    input  logic  bias_inv,
    output logic  bias_o,
    output logic  bias_oe
);

    logic active;
    logic tx_sense;

    always_comb begin
        active   = (state == MS_RX) || (state == MS_TX);
        tx_sense = (state == MS_TX);
        bias_oe  = bias_en && (state != MS_OFF);
        if (!bias_oe || !active) begin
            bias_o = 1'b0;
        end else if (bias_dual) begin
            bias_o = tx_sense ^ bias_inv;
        end else begin
            bias_o = tx_sense;
        end
    end

endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
    import mode_pkg::*;
#(
    parameter int BOOT_TICKS      = 160000,
    parameter int HIB_WAKE_TICKS  = 112000,
    parameter int DOZE_WAKE_TICKS = 4800,
    parameter int WARM_TICKS      = 2304
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       attn_n,
    input  logic       rxtx_en,
    input  logic       seq_tx_sel,
    input  logic       lp_req,
    input  logic       lp_hib_sel,
    input  logic       tmr_match,
    input  logic       seq_cmpl,
    input  logic       bias_en,
    input  logic       bias_dual,
    input  logic       bias_inv,
    input  logic       alt_gpio_en,
    output logic [3:0] mode_o,
    output logic       rx_on_o,
    output logic       tx_on_o,
    output logic       seq_done_o,
    output logic       out_of_idle_o,
    output logic       bias_o,
    output logic       bias_oe_o
);

    mode_e state;
    logic  busy;

    mode_fsm #(
        .BOOT_TICKS      (BOOT_TICKS),
        .HIB_WAKE_TICKS  (HIB_WAKE_TICKS),
        .DOZE_WAKE_TICKS (DOZE_WAKE_TICKS),
        .WARM_TICKS      (WARM_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .attn_n     (attn_n),
        .rxtx_en    (rxtx_en),
        .seq_tx_sel (seq_tx_sel),
        .lp_req     (lp_req),
        .lp_hib_sel (lp_hib_sel),
        .tmr_match  (tmr_match),
        .seq_cmpl   (seq_cmpl),
        .state      (state),
        .rx_on      (rx_on_o),
        .tx_on      (tx_on_o),
        .seq_done   (seq_done_o),
        .busy       (busy)
    );

    bias_drive u_bias (
        .state     (state),
        .bias_en   (bias_en),
        .bias_dual (bias_dual),
        .bias_inv  (bias_inv),
        .bias_o    (bias_o),
        .bias_oe   (bias_oe_o)
    );

    assign mode_o        = state;
    assign out_of_idle_o = alt_gpio_en && busy;

endmodule

// File: rtl/mode_ctrl_chk.sv
module mode_ctrl_chk
    import mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       attn_n,
    input logic       rxtx_en,
    input logic       seq_tx_sel,
    input logic       lp_req,
    input logic       lp_hib_sel,
    input logic       tmr_match,
    input logic       seq_cmpl,
    input logic       bias_en,
    input logic       bias_dual,
    input logic       bias_inv,
    input logic       alt_gpio_en,
    input logic [3:0] mode_o,
    input logic       rx_on_o,
    input logic       tx_on_o,
    input logic       seq_done_o,
    input logic       out_of_idle_o,
    input logic       bias_o,
    input logic       bias_oe_o
);

    // R1
    off_in_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (mode_o == MS_OFF));

    // R3
    sleep_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == MS_HIB) || (mode_o == MS_DOZE)) |->
        (($past(mode_o) == mode_o) || ($past(mode_o) == MS_IDLE)));

    // R4
    hib_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == MS_HIB) && attn_n) |=> (mode_o == MS_HIB));

    // R5
    doze_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == MS_DOZE) && attn_n && !tmr_match) |=> (mode_o == MS_DOZE));

    // R6
    arm_from_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_on_o || tx_on_o) && ($past(mode_o) != mode_o)) |-> ($past(mode_o) == MS_WARM));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxtx_en && ((mode_o == MS_WARM) || (mode_o == MS_RX) ||
                      (mode_o == MS_TX) || (mode_o == MS_HOLD))) |=> (mode_o == MS_IDLE));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> ((mode_o == MS_HOLD) &&
                        (($past(mode_o) == MS_RX) || ($past(mode_o) == MS_TX))));

    // R9
    tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_en || !bias_oe_o) |-> (!bias_oe_o && !bias_o));

    // R10
    single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_oe_o && !bias_dual && (rx_on_o || tx_on_o)) |-> (bias_o == tx_on_o));

    // R12
    bias_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_on_o && !tx_on_o) |-> !bias_o);

    // R13
    ooi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_gpio_en |-> !out_of_idle_o);

endmodule

bind radio_mode_ctrl mode_ctrl_chk u_chk (.*);

// File: tb/sim_radio_mode_ctrl.sv
`timescale 1ns/1ps
module sim_radio_mode_ctrl;
    import mode_pkg::*;

    localparam int BOOT_T = 4;
    localparam int HIB_T  = 5;
    localparam int DOZE_T = 3;
    localparam int WARM_T = 6;

    logic clk = 1'b0;
    logic rst_n, attn_n, rxtx_en, seq_tx_sel, lp_req, lp_hib_sel, tmr_match, seq_cmpl;
    logic bias_en, bias_dual, bias_inv, alt_gpio_en;
    logic [3:0] mode_o;
    logic rx_on_o, tx_on_o, seq_done_o, out_of_idle_o, bias_o, bias_oe_o;

    int nchk = 0;
    int nerr = 0;

    // bench model state
    mode_e em = MS_OFF;
    int    ecnt = 0;
    logic  edir = 1'b0;
    logic  erxq = 1'b0;
    logic  edone = 1'b0;

    always #5 clk = ~clk;

    radio_mode_ctrl #(
        .BOOT_TICKS(BOOT_T), .HIB_WAKE_TICKS(HIB_T),
        .DOZE_WAKE_TICKS(DOZE_T), .WARM_TICKS(WARM_T)
    ) u0 (.*);

    function automatic string req_of(input mode_e m);
        case (m)
            MS_OFF:           return "R1";
            MS_WAKE:          return "R2";
            MS_IDLE:          return "R3";
            MS_HIB:           return "R4";
            MS_DOZE:          return "R5";
            MS_WARM:          return "R6";
            default:          return "R8";
        endcase
    endfunction

    function automatic logic exp_oe(input mode_e m, input logic en);
        return en && (m != MS_OFF);
    endfunction

    function automatic logic exp_bias(input mode_e m, input logic en,
                                      input logic dual, input logic inv);
        if (!exp_oe(m, en)) return 1'b0;
        if ((m != MS_RX) && (m != MS_TX)) return 1'b0;
        return dual ? ((m == MS_TX) ^ inv) : (m == MS_TX);
    endfunction

    function automatic logic exp_ooi(input mode_e m, input logic alt);
        return alt && ((m == MS_WARM) || (m == MS_RX) || (m == MS_TX) || (m == MS_HOLD));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        mode_e nm;
        logic  nd;
        logic  edge_seen;
        if (!rst_n) begin
            em = MS_OFF; erxq = 1'b0; edone = 1'b0;
        end else begin
            nm = em; nd = 1'b0;
            edge_seen = rxtx_en && !erxq;
            case (em)
                MS_OFF:  begin nm = MS_WAKE; ecnt = BOOT_T - 1; end
                MS_WAKE: if (ecnt == 0) nm = MS_IDLE; else ecnt--;
                MS_IDLE: begin
                    if (edge_seen) begin nm = MS_WARM; ecnt = WARM_T - 1; edir = seq_tx_sel; end
                    else if (lp_req) nm = lp_hib_sel ? MS_HIB : MS_DOZE;
                end
                MS_HIB:  if (!attn_n) begin nm = MS_WAKE; ecnt = HIB_T - 1; end
                MS_DOZE: if (!attn_n || tmr_match) begin nm = MS_WAKE; ecnt = DOZE_T - 1; end
                MS_WARM: begin
                    if (!rxtx_en) nm = MS_IDLE;
                    else if (ecnt == 0) nm = edir ? MS_TX : MS_RX;
                    else ecnt--;
                end
                MS_RX, MS_TX: begin
                    if (!rxtx_en) nm = MS_IDLE;
                    else if (seq_cmpl) begin nm = MS_HOLD; nd = 1'b1; end
                end
                default: if (!rxtx_en) nm = MS_IDLE;
            endcase
            em = nm; edone = nd; erxq = rxtx_en;
        end
    endtask

    task automatic compare();
        logic eb;
        chk(mode_o == em, req_of(em), "mode", mode_o, em);
        chk(seq_done_o == edone, "R8", "seq_done", seq_done_o, edone);
        chk({rx_on_o, tx_on_o} == {em == MS_RX, em == MS_TX}, "R6", "rx/tx on",
            {rx_on_o, tx_on_o}, {em == MS_RX, em == MS_TX});
        chk(bias_oe_o == exp_oe(em, bias_en), "R9", "bias_oe", bias_oe_o, exp_oe(em, bias_en));
        eb = exp_bias(em, bias_en, bias_dual, bias_inv);
        if (!exp_oe(em, bias_en))
            chk(bias_o == eb, "R9", "bias hi-z value", bias_o, eb);
        else if ((em == MS_RX) || (em == MS_TX))
            chk(bias_o == eb, bias_dual ? "R11" : "R10", "bias", bias_o, eb);
        else
            chk(bias_o == eb, "R12", "bias idle", bias_o, eb);
        chk(out_of_idle_o == exp_ooi(em, alt_gpio_en), "R13", "out_of_idle",
            out_of_idle_o, exp_ooi(em, alt_gpio_en));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; attn_n = 1'b1; rxtx_en = 1'b1; seq_tx_sel = 1'b0;
        lp_req = 1'b0; lp_hib_sel = 1'b0; tmr_match = 1'b0; seq_cmpl = 1'b0;
        bias_en = 1'b1; bias_dual = 1'b0; bias_inv = 1'b1; alt_gpio_en = 1'b1;
        repeat (3) tick();                       // R1 under reset
        rst_n = 1'b1;
        n = 0; tick();
        while (mode_o == MS_WAKE && n < 100) begin n++; tick(); end
        chk(n == BOOT_T, "R2", "boot wake cycles", n, BOOT_T);
        tick();
        chk(mode_o == MS_IDLE, "R6", "level without edge starts nothing", mode_o, MS_IDLE);

        // start a transmit sequence, count warm-up
        rxtx_en = 1'b0; tick();
        rxtx_en = 1'b1; seq_tx_sel = 1'b1; tick();
        seq_tx_sel = 1'b0;                        // captured at edge only
        n = 0;
        while (mode_o == MS_WARM && n < 100) begin n++; tick(); end
        chk(n == WARM_T, "R6", "warm-up cycles", n, WARM_T);
        chk(mode_o == MS_TX, "R6", "direction captured at edge", mode_o, MS_TX);
        chk(bias_o == 1'b1, "R10", "single port TX ignores invert", bias_o, 1);
        lp_req = 1'b1; lp_hib_sel = 1'b1; tick(); lp_req = 1'b0;
        chk(mode_o == MS_TX, "R3", "lp_req ignored while busy", mode_o, MS_TX);
        seq_cmpl = 1'b1; tick(); seq_cmpl = 1'b0;
        chk(seq_done_o == 1'b1, "R8", "done pulse", seq_done_o, 1);
        repeat (3) tick();
        chk(mode_o == MS_HOLD, "R8", "hold until release", mode_o, MS_HOLD);
        rxtx_en = 1'b0; tick();
        chk(mode_o == MS_IDLE, "R7", "release from hold", mode_o, MS_IDLE);

        // abort in warm-up
        rxtx_en = 1'b1; tick(); tick();
        rxtx_en = 1'b0; tick();
        chk(mode_o == MS_IDLE, "R7", "abort during warm-up", mode_o, MS_IDLE);

        // dual-port receive with invert
        bias_dual = 1'b1; bias_inv = 1'b1; seq_tx_sel = 1'b0;
        rxtx_en = 1'b1; repeat (WARM_T + 2) tick();
        chk(mode_o == MS_RX && bias_o == 1'b1, "R11", "dual port RX inverted", bias_o, 1);
        rxtx_en = 1'b0; tick();

        // hibernate: timer ignored, attention wakes
        lp_req = 1'b1; lp_hib_sel = 1'b1; tick(); lp_req = 1'b0;
        chk(mode_o == MS_HIB, "R3", "enter hibernate", mode_o, MS_HIB);
        chk(bias_o == 1'b0, "R12", "bias low in hibernate", bias_o, 0);
        tmr_match = 1'b1; repeat (2) tick(); tmr_match = 1'b0;
        chk(mode_o == MS_HIB, "R4", "timer ignored in hibernate", mode_o, MS_HIB);
        attn_n = 1'b0; tick(); attn_n = 1'b1;
        n = 0;
        while (mode_o == MS_WAKE && n < 100) begin n++; tick(); end
        chk(n == HIB_T, "R4", "hibernate wake cycles", n, HIB_T);

        // doze: timer wakes
        lp_req = 1'b1; lp_hib_sel = 1'b0; tick(); lp_req = 1'b0;
        chk(mode_o == MS_DOZE, "R3", "enter doze", mode_o, MS_DOZE);
        tmr_match = 1'b1; tick(); tmr_match = 1'b0;
        n = 0;
        while (mode_o == MS_WAKE && n < 100) begin n++; tick(); end
        chk(n == DOZE_T, "R5", "doze timer wake cycles", n, DOZE_T);

        bias_en = 1'b0; tick();
        chk(bias_oe_o == 1'b0, "R9", "bias tri-stated", bias_oe_o, 0);

        // weighted random phase, checked each cycle against the model
        for (int i = 0; i < 5000; i++) begin
            if (($urandom % 14) == 0) rxtx_en = ~rxtx_en;
            attn_n     = (($urandom % 20) != 0);
            tmr_match  = (($urandom % 25) == 0);
            lp_req     = (($urandom % 8) == 0);
            lp_hib_sel = $urandom % 2;
            seq_cmpl   = (($urandom % 10) == 0);
            seq_tx_sel = $urandom % 2;
            if (($urandom % 40) == 0) bias_en = ~bias_en;
            if (($urandom % 40) == 0) bias_dual = ~bias_dual;
            if (($urandom % 40) == 0) bias_inv = ~bias_inv;
            if (($urandom % 50) == 0) alt_gpio_en = ~alt_gpio_en;
            rst_n = (($urandom % 600) != 0);
            tick();
        end

        summary();
        $finish;
    end

endmodule